// File: doc/BRIEF.md
# Data Trace Synchronization Decision Controller

This block sits in front of a trace message queue. For every data-trace read/write message offered to it, it decides one of three things. The message may go out as a compact plain message. It may be promoted to a synchronization message that carries the full address, so that a trace tool can rebuild its address reference. Or it may be dropped. The result appears one cycle after the message strobe. The queue and the serializer downstream use it to pick the message type.

Several unrelated conditions can each require resynchronization. These are reset, trace being disabled, exit from low-power or debug mode, an external event pin, a queue overrun recovery, and a message lost to a secure access or to a queue-entry collision. All of them are merged into a single pending-sync flag. That flag is consumed only when a message actually goes out as a sync message. A periodic counter also forces a sync after a fixed number of consecutive plain messages.

Top module: `trace_sync_ctrl`

## Requirements
- R1: While rst_ni is low, res_vld_o is 0. The first message accepted after reset release with trace enabled is reported with sync_o=1, drop_o=0.
- R2: A msg_vld_i strobe while trc_en_i is 0 produces no result (res_vld_o stays 0).
- R3: While trc_en_i is 0 a sync is held pending, so the first message accepted after trace is enabled again is a sync message.
- R4: A one-cycle pulse on lp_exit_i or dbg_exit_i makes the next emitted message a sync message.
- R5: After a sync message, exactly PERIOD (default 255) plain messages are emitted, and the next emitted message is forced to sync. Any sync message, whatever caused it, restarts this count at zero. Dropped messages are not counted.
- R6: A rising edge of the asynchronous evt_in_i, seen while evt_en_i is 1, causes one sync on a message accepted 3 or more cycles after the edge. Holding the pin high gives no further sync. An edge seen while evt_en_i is 0 has no effect.
- R7: A message accepted with secure_viol_i=1 is reported with drop_o=1, sync_o=0, and the next emitted message is a sync message.
- R8: A message accepted with coll_lost_i=1 is reported with drop_o=1, sync_o=0, and the next emitted message is a sync message.
- R9: A one-cycle pulse on ovr_recov_i makes the next emitted message a sync message.
- R10: The pending sync is cleared only by an emitted sync message. A trigger that coincides with an accepted message applies to the following message, and a plain message with no trigger pending is reported with sync_o=0, drop_o=0.
- R11: An accepted message (msg_vld_i=1 with trc_en_i=1) gives res_vld_o=1 in exactly the next cycle. No other cycle has res_vld_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (trace interface reset) |
| trc_en_i | input | 1 | Data trace enable |
| lp_exit_i | input | 1 | Pulse: exit from low-power mode |
| dbg_exit_i | input | 1 | Pulse: exit from debug mode |
| evt_in_i | input | 1 | Asynchronous event-in pin |
| evt_en_i | input | 1 | Allows event-in to request a sync |
| secure_viol_i | input | 1 | Qualifies msg_vld_i: access hit secure memory |
| coll_lost_i | input | 1 | Qualifies msg_vld_i: message lost to a queue-entry collision |
| ovr_recov_i | input | 1 | Pulse: queue overrun recovery finished |
| msg_vld_i | input | 1 | A data-trace read/write message is offered |
| res_vld_o | output | 1 | Decision for the previous cycle's message is valid |
| sync_o | output | 1 | Message goes out as a sync message |
| drop_o | output | 1 | Message is discarded |

## Verification
The assertions assume that lp_exit_i, dbg_exit_i and ovr_recov_i are single-cycle pulses. They also assume that secure_viol_i and coll_lost_i only mean something in a cycle that has msg_vld_i, and that trc_en_i does not toggle in a cycle that carries a message. The stimulus drives every input on the falling clock edge. It raises each mode-exit and recovery pulse for exactly one cycle and keeps the qualifier flags tied to a message strobe. It leaves at least five cycles between an event-pin edge and the message that should absorb it, which covers the synchronizer latency.

// File: rtl/trace_sync_pkg.sv
package trace_sync_pkg;
  typedef enum logic [2:0] {
    TRG_DISABLED = 3'd0,
    TRG_LP_EXIT  = 3'd1,
    TRG_DBG_EXIT = 3'd2,
    TRG_EVENT    = 3'd3,
    TRG_OVERRUN  = 3'd4,
    TRG_LOST     = 3'd5
  } trg_e;

  localparam int unsigned NUM_TRG = 6;

  typedef struct packed {
    logic sync;
    logic drop;
  } dec_t;
endpackage

// File: rtl/tsc_evt_detect.sv
module tsc_evt_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R6
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tsc_trig_merge.sv
module tsc_trig_merge #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trg_i,
  input  logic         clr_i,
  output logic         pend_o
);
  logic pend_q;

  // reset itself leaves a sync pending
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= 1'b1;
    else         pend_q <= (pend_q & ~clr_i) | (|trg_i);

  assign pend_o = pend_q;

  // R10
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);

  // R10
  trig_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trg_i) |=> pend_q);
endmodule

// File: rtl/tsc_period_cnt.sv
module tsc_period_cnt #(
  parameter int unsigned PERIOD = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic plain_i,
  input  logic sync_i,
  output logic due_o
);
  localparam int unsigned CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PERIOD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (sync_i)  cnt_q <= '0;
    else if (plain_i) cnt_q <= cnt_q + 1'b1;

  assign due_o = (cnt_q == LIMIT);

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);

  // R5
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (cnt_q == '0));

  // R5
  no_plain_when_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |-> !plain_i);
endmodule

// File: rtl/trace_sync_ctrl.sv
module trace_sync_ctrl
  import trace_sync_pkg::*;
#(
  parameter int unsigned PERIOD     = 255,
  parameter int unsigned EVT_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trc_en_i,
  input  logic lp_exit_i,
  input  logic dbg_exit_i,
  input  logic evt_in_i,
  input  logic evt_en_i,
  input  logic secure_viol_i,
  input  logic coll_lost_i,
  input  logic ovr_recov_i,
  input  logic msg_vld_i,
  output logic res_vld_o,
  output logic sync_o,
  output logic drop_o
);
  logic               evt_rise;
  logic               pend;
  logic               due;
  logic               accept;
  logic               lost;
  logic               emit;
  logic               sync_now;
  logic [NUM_TRG-1:0] trg;
  dec_t               dec_d, dec_q;
  logic               vld_q;

  tsc_evt_detect #(.STAGES(EVT_STAGES)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (evt_in_i),
    .rise_o (evt_rise)
  );

  assign accept   = msg_vld_i & trc_en_i;
  assign lost     = accept & (secure_viol_i | coll_lost_i);
  assign emit     = accept & ~lost;
  assign sync_now = pend | due;

  always_comb begin
    trg               = '0;
    trg[TRG_DISABLED] = ~trc_en_i;
    trg[TRG_LP_EXIT]  = lp_exit_i;
    trg[TRG_DBG_EXIT] = dbg_exit_i;
    trg[TRG_EVENT]    = evt_rise & evt_en_i;
    trg[TRG_OVERRUN]  = ovr_recov_i;
    trg[TRG_LOST]     = lost;
  end

  tsc_trig_merge #(.N(NUM_TRG)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trg_i  (trg),
    .clr_i  (emit & sync_now),
    .pend_o (pend)
  );

  tsc_period_cnt #(.PERIOD(PERIOD)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .plain_i (emit & ~sync_now),
    .sync_i  (emit & sync_now),
    .due_o   (due)
  );

  always_comb begin
    dec_d.drop = lost;
    dec_d.sync = emit & sync_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dec_q <= '0;
    end else begin
      vld_q <= accept;
      dec_q <= accept ? dec_d : '0;
    end

  assign res_vld_o = vld_q;
  assign sync_o    = dec_q.sync;
  assign drop_o    = dec_q.drop;

  // R11
  res_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> res_vld_o);

  // R11
  no_spurious_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !res_vld_o);

  // R7
  drop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && drop_o) |-> !sync_o);

  // R8
  lost_pends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && coll_lost_i) |=> pend);

  // R4
  exit_pends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_exit_i || dbg_exit_i) |=> pend);

  // R3
  disabled_pends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trc_en_i |=> pend);
endmodule

// File: tb/tb_trace_sync_ctrl.sv
module tb_trace_sync_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic trc_en_i = 1'b1, lp_exit_i = 1'b0, dbg_exit_i = 1'b0;
  logic evt_in_i = 1'b0, evt_en_i = 1'b0;
  logic secure_viol_i = 1'b0, coll_lost_i = 1'b0, ovr_recov_i = 1'b0;
  logic msg_vld_i = 1'b0;
  logic res_vld_o, sync_o, drop_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  sync;
    logic  drop;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  trace_sync_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .trc_en_i(trc_en_i),
    .lp_exit_i(lp_exit_i), .dbg_exit_i(dbg_exit_i),
    .evt_in_i(evt_in_i), .evt_en_i(evt_en_i),
    .secure_viol_i(secure_viol_i), .coll_lost_i(coll_lost_i),
    .ovr_recov_i(ovr_recov_i), .msg_vld_i(msg_vld_i),
    .res_vld_o(res_vld_o), .sync_o(sync_o), .drop_o(drop_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare on the falling edge
  always @(negedge clk_i) begin
    if (rst_ni && res_vld_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(sync_o == e.sync && drop_o == e.drop, e.req, "sync/drop",
              {30'd0, sync_o, drop_o}, {30'd0, e.sync, e.drop});
      end
    end
  end

  task automatic send(input logic s, input logic d, input logic sec,
                      input logic col, input string req);
    exp_t e;
    e.sync = s; e.drop = d; e.req = req;
    exp_q.push_back(e);
    msg_vld_i = 1'b1; secure_viol_i = sec; coll_lost_i = col;
    @(negedge clk_i);
    msg_vld_i = 1'b0; secure_viol_i = 1'b0; coll_lost_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse_lp();
    lp_exit_i = 1'b1; @(negedge clk_i); lp_exit_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    check(res_vld_o == 1'b0, "R1", "res_vld_o in reset", int'(res_vld_o), 0);
    rst_ni = 1'b1;
    idle(2);
    send(1, 0, 0, 0, "R1");
    send(0, 0, 0, 0, "R10");
    send(0, 0, 0, 0, "R10");
    // R4: low-power and debug exit
    pulse_lp();
    send(1, 0, 0, 0, "R4");
    send(0, 0, 0, 0, "R4");
    dbg_exit_i = 1'b1; @(negedge clk_i); dbg_exit_i = 1'b0;
    send(1, 0, 0, 0, "R4");
    // R9: overrun recovery
    ovr_recov_i = 1'b1; @(negedge clk_i); ovr_recov_i = 1'b0;
    send(1, 0, 0, 0, "R9");
    send(0, 0, 0, 0, "R9");
    // R10: trigger coincident with message applies to the next one
    lp_exit_i = 1'b1;
    send(0, 0, 0, 0, "R10");
    lp_exit_i = 1'b0;
    send(1, 0, 0, 0, "R10");
    // R7: secure violation
    send(0, 1, 1, 0, "R7");
    send(1, 0, 0, 0, "R7");
    send(0, 0, 0, 0, "R7");
    // R8: collision loss
    send(0, 1, 0, 1, "R8");
    send(1, 0, 0, 0, "R8");
    send(0, 0, 0, 0, "R8");
    // R6: event pin, single sync per assertion
    evt_en_i = 1'b1; evt_in_i = 1'b1;
    idle(5);
    send(1, 0, 0, 0, "R6");
    idle(5);
    send(0, 0, 0, 0, "R6");
    evt_in_i = 1'b0; idle(5);
    evt_en_i = 1'b0; evt_in_i = 1'b1; idle(5);
    send(0, 0, 0, 0, "R6");
    evt_in_i = 1'b0; idle(5);
    // R2: ignored while disabled
    trc_en_i = 1'b0; idle(1);
    msg_vld_i = 1'b1; @(negedge clk_i); msg_vld_i = 1'b0;
    check(res_vld_o == 1'b0, "R2", "res_vld_o while disabled", int'(res_vld_o), 0);
    idle(1);
    check(res_vld_o == 1'b0, "R2", "res_vld_o after disabled msg", int'(res_vld_o), 0);
    // R3: re-enable
    trc_en_i = 1'b1; idle(1);
    send(1, 0, 0, 0, "R3");
    // R5: periodic sync
    for (int i = 0; i < 255; i++) send(0, 0, 0, 0, "R5");
    send(1, 0, 0, 0, "R5");
    send(0, 0, 0, 0, "R5");
    // R5: dropped messages not counted, other syncs restart the count
    for (int i = 0; i < 99; i++) send(0, 0, 0, 0, "R5");
    pulse_lp();
    send(1, 0, 0, 0, "R5");
    for (int i = 0; i < 200; i++) send(0, 0, 0, 0, "R5");
    send(0, 1, 1, 0, "R5");
    send(1, 0, 0, 0, "R5");
    for (int i = 0; i < 255; i++) send(0, 0, 0, 0, "R5");
    send(1, 0, 0, 0, "R5");
    idle(3);
    check(exp_q.size() == 0, "R11", "results outstanding", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule